// File: doc/BRIEF.md
# Boost Switch Protection Gate

This block sits between the fault comparators of a boost converter and its power switch driver. Each clock it combines the comparator flags (over-current, over-voltage, output short, supply undervoltage, standby, over-temperature) with the oscillator's set pulse and the current-mode comparator's turn-off pulse. From them it decides whether the switch output may be on in the present cycle. It also produces a whole-system stop, a soft-start discharge command, a stop for the LED drivers and a request to the external fault timer.

Each fault class gets its own response. Over-current ends only the present switching cycle. Over-voltage holds the switch off for as long as the flag is present. An output short holds the switch off, and in latch mode it asks the fault timer to run. When the timer reports expiry, the block latches a system stop, which only a fail-reset, undervoltage or standby can clear. In one-shot mode a short only holds the switch off. The block also stops switching once every LED channel has been stopped. It selects the over-voltage divider as loop feedback while soft-start is still running and all dimming inputs are low.

Every output is a register fed by the present inputs, so a change at the inputs shows at the outputs after the next rising clock edge.

Top module: `boost_prot_gate`

## Requirements
- R1: While reset is asserted and right after it, gateOut, sysStop, ssDischarge, ledStop, timerReq and fbFromOvp are all low.
- R2: With no fault present, oscSet high at an edge makes gateOut high after that edge. gateOut stays high on idle cycles. cmpOff high at a later edge makes it low.
- R3: ocpFlag high at an edge makes gateOut low after that edge. gateOut stays low until the next oscSet, even after the flag drops. An oscSet seen together with ocpFlag leaves gateOut low. The next oscSet without the flag turns it on again.
- R4: ovpFlag high holds gateOut low and ignores oscSet. It leaves sysStop low. After the flag clears, the next oscSet turns gateOut on with no reset needed.
- R5: In latch mode (failMode=0), scpFlag high holds gateOut low and drives timerReq high. sysStop stays low while timerDone is low.
- R6: In latch mode, scpFlag and timerDone high together at an edge raise sysStop, ssDischarge and ledStop after that edge and drop timerReq. These outputs stay high after both inputs clear, and gateOut stays low on oscSet.
- R7: A latched system stop is cleared by failRst, by uvloFlag or by stbyFlag. While failRst is high, a short with timerDone does not latch.
- R8: In one-shot mode (failMode=1), scpFlag holds gateOut low while present. timerReq stays low, and sysStop stays low even with timerDone high. After the flag clears, oscSet turns gateOut on.
- R9: uvloFlag, stbyFlag or tsdFlag each drive sysStop, ssDischarge and ledStop high and gateOut low while present. These outputs fall one edge after the flag clears.
- R10: When every bit of chanStopped is high, gateOut stays low on oscSet. With any bit low, switching works normally.
- R11: fbFromOvp is high exactly when ssDone is low and every bit of pwmIn is low.
- R12: Any stop condition present in the same cycle as oscSet wins, and gateOut stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscSet | input | 1 | Oscillator pulse that opens a switching cycle |
| cmpOff | input | 1 | Current-mode comparator pulse that ends the on time |
| ocpFlag | input | 1 | Switch over-current comparator |
| ovpFlag | input | 1 | Output over-voltage comparator |
| scpFlag | input | 1 | Output short comparator |
| uvloFlag | input | 1 | Converter supply undervoltage |
| stbyFlag | input | 1 | Standby request |
| tsdFlag | input | 1 | Over-temperature |
| failMode | input | 1 | 0 selects latch mode, 1 selects one-shot mode |
| timerDone | input | 1 | Fault timer expired |
| failRst | input | 1 | Clears and masks the latched stop |
| ssDone | input | 1 | Soft-start finished |
| pwmIn | input | NUM_CH | Per-channel dimming inputs |
| chanStopped | input | NUM_CH | Per-channel stopped indications |
| gateOut | output | 1 | Switch driver enable |
| sysStop | output | 1 | Whole-system stop |
| ssDischarge | output | 1 | Soft-start discharge command |
| ledStop | output | 1 | LED driver stop |
| timerReq | output | 1 | Fault timer run request |
| fbFromOvp | output | 1 | Selects the over-voltage divider as loop feedback |

## Verification
The bench probes the cycle after an over-current hit, where a design that only gated the live flag would turn the switch back on before the next oscillator pulse. It releases an over-voltage or one-shot short and then pulses the oscillator, which catches a design that latched those faults. It drops the short and the timer after latching and checks that the stop holds, and it holds fail-reset during a short with timer expiry, which exposes a design where setting beats clearing. It also fires the oscillator in the same cycle as a stop to confirm that the stop wins.

// File: rtl/boost_prot_pkg.sv
package boost_prot_pkg;

  // Decisions handed from the fault control to the switch datapath.
  typedef struct packed {
    logic swStop;    // switching must be held off this cycle
    logic ocpHit;    // over-current: end the present cycle
    logic turnOff;   // normal end of on time
    logic sysStop;   // whole-system stop (latched or supply/standby/thermal)
    logic timerReq;  // ask the fault timer to run
  } protStrobe_t;

endpackage

// File: rtl/boost_prot_chan.sv
module boost_prot_chan #(
  parameter int NUM_CH = 6
) (
  input  logic [NUM_CH-1:0] pwmIn,
  input  logic [NUM_CH-1:0] chanStopped,
  output logic              allStopped,
  output logic              anyPwm
);

  localparam int LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] stopChain;
  logic [NUM_CH-1:0] pwmChain;

  assign stopChain[0] = chanStopped[0];
  assign pwmChain[0]  = pwmIn[0];

  genvar gi;
  generate
    for (gi = 1; gi < NUM_CH; gi++) begin : gChain
      assign stopChain[gi] = stopChain[gi-1] & chanStopped[gi];
      assign pwmChain[gi]  = pwmChain[gi-1]  | pwmIn[gi];
    end
  endgenerate

  assign allStopped = stopChain[LAST];
  assign anyPwm     = pwmChain[LAST];

endmodule

// File: rtl/boost_prot_ctrl.sv
module boost_prot_ctrl
  import boost_prot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmpOff,
  input  logic        ocpFlag,
  input  logic        ovpFlag,
  input  logic        scpFlag,
  input  logic        uvloFlag,
  input  logic        stbyFlag,
  input  logic        tsdFlag,
  input  logic        failMode,
  input  logic        timerDone,
  input  logic        failRst,
  input  logic        allStopped,
  output protStrobe_t strb
);

  logic sysLatch;
  logic latchClr;
  logic latchSet;
  logic latchNext;
  logic supplyStop;

  // Clearing sources dominate: a held fail-reset masks a new latch.
  assign latchClr   = failRst | uvloFlag | stbyFlag;
  assign latchSet   = ~failMode & scpFlag & timerDone;
  assign supplyStop = uvloFlag | stbyFlag | tsdFlag;

  always_comb begin
    if (latchClr) latchNext = 1'b0;
    else          latchNext = sysLatch | latchSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysLatch <= 1'b0;
    else       sysLatch <= latchNext;
  end

  always_comb begin
    strb.sysStop  = latchNext | supplyStop;
    strb.swStop   = strb.sysStop | ovpFlag | scpFlag | allStopped;
    strb.ocpHit   = ocpFlag;
    strb.turnOff  = cmpOff;
    strb.timerReq = ~failMode & scpFlag & ~latchNext;
  end

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sysLatch && !failRst && !uvloFlag && !stbyFlag) |=> sysLatch); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (failRst || uvloFlag || stbyFlag) |=> !sysLatch); // R7
  AST_ONESHOT_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (failMode && !sysLatch) |=> !sysLatch); // R8

endmodule

// File: rtl/boost_prot_dp.sv
module boost_prot_dp
  import boost_prot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscSet,
  input  protStrobe_t strb,
  input  logic        ssDone,
  input  logic        anyPwm,
  output logic        gateOut,
  output logic        sysStop,
  output logic        ssDischarge,
  output logic        ledStop,
  output logic        timerReq,
  output logic        fbFromOvp
);

  logic gateQ;
  logic gateNext;

  // Priority: stop > over-current > oscillator set > comparator off > hold.
  always_comb begin
    if (strb.swStop)      gateNext = 1'b0;
    else if (strb.ocpHit) gateNext = 1'b0;
    else if (oscSet)      gateNext = 1'b1;
    else if (strb.turnOff) gateNext = 1'b0;
    else                  gateNext = gateQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ       <= 1'b0;
      sysStop     <= 1'b0;
      ssDischarge <= 1'b0;
      ledStop     <= 1'b0;
      timerReq    <= 1'b0;
      fbFromOvp   <= 1'b0;
    end else begin
      gateQ       <= gateNext;
      sysStop     <= strb.sysStop;
      ssDischarge <= strb.sysStop;
      ledStop     <= strb.sysStop;
      timerReq    <= strb.timerReq;
      fbFromOvp   <= ~ssDone & ~anyPwm;
    end
  end

  assign gateOut = gateQ;

  AST_GATE_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateQ) |-> $past(oscSet)); // R2
  AST_OCP_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ocpHit |=> !gateQ); // R3
  AST_STOP_BEATS_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.swStop |=> !gateQ); // R12
  AST_SYSSTOP_GATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    sysStop |-> !gateQ); // R9

endmodule

// File: rtl/boost_prot_gate.sv
module boost_prot_gate
  import boost_prot_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscSet,
  input  logic              cmpOff,
  input  logic              ocpFlag,
  input  logic              ovpFlag,
  input  logic              scpFlag,
  input  logic              uvloFlag,
  input  logic              stbyFlag,
  input  logic              tsdFlag,
  input  logic              failMode,
  input  logic              timerDone,
  input  logic              failRst,
  input  logic              ssDone,
  input  logic [NUM_CH-1:0] pwmIn,
  input  logic [NUM_CH-1:0] chanStopped,
  output logic              gateOut,
  output logic              sysStop,
  output logic              ssDischarge,
  output logic              ledStop,
  output logic              timerReq,
  output logic              fbFromOvp
);

  protStrobe_t strb;
  logic        allStopped;
  logic        anyPwm;

  boost_prot_chan #(.NUM_CH(NUM_CH)) uChan (
    .pwmIn       (pwmIn),
    .chanStopped (chanStopped),
    .allStopped  (allStopped),
    .anyPwm      (anyPwm)
  );

  boost_prot_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmpOff     (cmpOff),
    .ocpFlag    (ocpFlag),
    .ovpFlag    (ovpFlag),
    .scpFlag    (scpFlag),
    .uvloFlag   (uvloFlag),
    .stbyFlag   (stbyFlag),
    .tsdFlag    (tsdFlag),
    .failMode   (failMode),
    .timerDone  (timerDone),
    .failRst    (failRst),
    .allStopped (allStopped),
    .strb       (strb)
  );

  boost_prot_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .oscSet      (oscSet),
    .strb        (strb),
    .ssDone      (ssDone),
    .anyPwm      (anyPwm),
    .gateOut     (gateOut),
    .sysStop     (sysStop),
    .ssDischarge (ssDischarge),
    .ledStop     (ledStop),
    .timerReq    (timerReq),
    .fbFromOvp   (fbFromOvp)
  );

endmodule

// File: tb/boost_prot_gate_test.sv
module boost_prot_gate_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscSet = 0, cmpOff = 0, ocpFlag = 0, ovpFlag = 0, scpFlag = 0;
  logic uvloFlag = 0, stbyFlag = 0, tsdFlag = 0, failMode = 0;
  logic timerDone = 0, failRst = 0, ssDone = 1;
  logic [NCH-1:0] pwmIn = '1;
  logic [NCH-1:0] chanStopped = '0;
  logic gateOut, sysStop, ssDischarge, ledStop, timerReq, fbFromOvp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_prot_gate #(.NUM_CH(NCH)) uut (
    .clk(clk), .rstN(rstN), .oscSet(oscSet), .cmpOff(cmpOff),
    .ocpFlag(ocpFlag), .ovpFlag(ovpFlag), .scpFlag(scpFlag),
    .uvloFlag(uvloFlag), .stbyFlag(stbyFlag), .tsdFlag(tsdFlag),
    .failMode(failMode), .timerDone(timerDone), .failRst(failRst),
    .ssDone(ssDone), .pwmIn(pwmIn), .chanStopped(chanStopped),
    .gateOut(gateOut), .sysStop(sysStop), .ssDischarge(ssDischarge),
    .ledStop(ledStop), .timerReq(timerReq), .fbFromOvp(fbFromOvp)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Inputs change at the falling edge; one rising edge passes; sample at next falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulseSet();
    oscSet = 1; step(); oscSet = 0;
  endtask

  task automatic testReset();
    chk("R1 gateOut", gateOut, 0);
    chk("R1 sysStop", sysStop, 0);
    chk("R1 ssDischarge", ssDischarge, 0);
    chk("R1 ledStop", ledStop, 0);
    chk("R1 timerReq", timerReq, 0);
    chk("R1 fbFromOvp", fbFromOvp, 0);
  endtask

  task automatic testNormal();
    pulseSet();
    chk("R2 on after set", gateOut, 1);
    step();
    chk("R2 holds on", gateOut, 1);
    cmpOff = 1; step(); cmpOff = 0;
    chk("R2 off after cmpOff", gateOut, 0);
  endtask

  task automatic testOcp();
    pulseSet();
    chk("R3 on", gateOut, 1);
    ocpFlag = 1; step(); ocpFlag = 0;
    chk("R3 blanked", gateOut, 0);
    step();
    chk("R3 stays blanked", gateOut, 0);
    ocpFlag = 1; oscSet = 1; step(); ocpFlag = 0; oscSet = 0;
    chk("R3 set with ocp", gateOut, 0);
    pulseSet();
    chk("R3 next cycle restarts", gateOut, 1);
    cmpOff = 1; step(); cmpOff = 0;
  endtask

  task automatic testOvp();
    pulseSet();
    ovpFlag = 1; step();
    chk("R4 off under ovp", gateOut, 0);
    pulseSet();
    chk("R12 ovp beats set", gateOut, 0);
    chk("R4 no sysStop", sysStop, 0);
    ovpFlag = 0; step();
    chk("R4 not latched, waits for set", gateOut, 0);
    pulseSet();
    chk("R4 resumes", gateOut, 1);
    cmpOff = 1; step(); cmpOff = 0;
  endtask

  task automatic latchScp();
    scpFlag = 1; timerDone = 1; step(); scpFlag = 0; timerDone = 0;
  endtask

  task automatic testScpLatch();
    failMode = 0;
    pulseSet();
    scpFlag = 1; step();
    chk("R5 gate off", gateOut, 0);
    chk("R5 timerReq", timerReq, 1);
    chk("R5 no sysStop yet", sysStop, 0);
    timerDone = 1; step();
    chk("R6 sysStop", sysStop, 1);
    chk("R6 ssDischarge", ssDischarge, 1);
    chk("R6 ledStop", ledStop, 1);
    chk("R6 timerReq drops", timerReq, 0);
    scpFlag = 0; timerDone = 0; pulseSet();
    chk("R6 latched sysStop", sysStop, 1);
    chk("R6 gate stays off", gateOut, 0);
    failRst = 1; step();
    chk("R7 failRst clears", sysStop, 0);
    scpFlag = 1; timerDone = 1; step();
    chk("R7 failRst masks latch", sysStop, 0);
    scpFlag = 0; timerDone = 0; failRst = 0; step();
    chk("R7 still clear", sysStop, 0);
    latchScp();
    chk("R6 latch again", sysStop, 1);
    uvloFlag = 1; step(); uvloFlag = 0; step();
    chk("R7 uvlo clears latch", sysStop, 0);
    latchScp();
    stbyFlag = 1; step(); stbyFlag = 0; step();
    chk("R7 standby clears latch", ssDischarge, 0);
  endtask

  task automatic testOneShot();
    failMode = 1;
    pulseSet();
    scpFlag = 1; step();
    chk("R8 gate off", gateOut, 0);
    chk("R8 no timerReq", timerReq, 0);
    timerDone = 1; step();
    chk("R8 no latch", sysStop, 0);
    scpFlag = 0; timerDone = 0; step();
    chk("R8 still no stop", sysStop, 0);
    pulseSet();
    chk("R8 resumes", gateOut, 1);
    cmpOff = 1; step(); cmpOff = 0;
    failMode = 0;
  endtask

  task automatic testSupply();
    pulseSet();
    uvloFlag = 1; step();
    chk("R9 uvlo sysStop", sysStop, 1);
    chk("R9 uvlo ledStop", ledStop, 1);
    chk("R9 uvlo gate off", gateOut, 0);
    uvloFlag = 0; step();
    chk("R9 uvlo release", ssDischarge, 0);
    tsdFlag = 1; step();
    chk("R9 tsd ssDischarge", ssDischarge, 1);
    tsdFlag = 0; step();
    chk("R9 tsd release", ledStop, 0);
    uvloFlag = 1; oscSet = 1; step(); uvloFlag = 0; oscSet = 0;
    chk("R12 uvlo beats set", gateOut, 0);
  endtask

  task automatic testChannels();
    chanStopped = '1;
    pulseSet();
    chk("R10 all stopped", gateOut, 0);
    chanStopped = 6'b111011;
    pulseSet();
    chk("R10 one running", gateOut, 1);
    cmpOff = 1; step(); cmpOff = 0;
    chanStopped = '0;
  endtask

  task automatic testFb();
    ssDone = 0; pwmIn = '0; step();
    chk("R11 fb from ovp", fbFromOvp, 1);
    pwmIn = 6'b100000; step();
    chk("R11 one pwm high", fbFromOvp, 0);
    pwmIn = '0; ssDone = 1; step();
    chk("R11 after soft-start", fbFromOvp, 0);
    pwmIn = '1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    step();
    testReset();
    testNormal();
    testOcp();
    testOvp();
    testScpLatch();
    testOneShot();
    testSupply();
    testChannels();
    testFb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule